// File: doc/BRIEF.md
# Wake Event Controller

This block collects wake-up events from several places in a system and drives a single power-management request pin. The event sources are a set of general-purpose inputs, two ring-indicator lines, the keyboard and mouse data lines, a fan tachometer event pulse, and an internal grouped system-management signal. Every edge-triggered source has a sticky status bit and an enable bit. The bits sit in byte-wide status and enable registers, which a simple synchronous register port reads and writes. Status bits clear when a 1 is written to them.

A request is pending while any status bit and its matching enable bit are both set. The pin shows a pending request only when the global enable is on. Software chooses the pin's active level and whether it is driven push-pull or open-drain. The open-drain form uses a low-active output-enable with a constant data value. The asynchronous inputs are synchronized with two flops before edge detection.

Register map (3-bit address): 0 control (bit0 global enable, bit1 pending summary, read-only); 1 output configuration (bit0 active-high, bit5 route grouped signal, bit7 push-pull); 2 GPIO status; 3 GPIO enable; 4 misc status (bit0 ring 0, bit1 ring 1, bit2 keyboard, bit3 grouped-signal mirror, bit4 mouse, bit5 fan); 5 misc enable; 6 GPIO invert; 7 GPIO both-edges. Bits that are not defined read 0.

Top module: `wake_event_ctrl`

## Requirements
- R1: A source's status bit becomes set on its active edge whether or not the global enable (control bit0) is set.
- R2: While the global enable is 0, the pin never shows the active state.
- R3: While the global enable is 1, the pin is active if any status bit and its enable bit are both 1. A source that is set but not enabled does not activate the pin.
- R4: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A status bit stays set until it is cleared.
- R5: The pending summary (control bit1) and the pin stay active until every enabled pending status bit has been cleared.
- R6: A GPIO whose invert bit (register 6) is 0 sets its status on a rising edge only. With the invert bit at 1, it sets on a falling edge only.
- R7: A GPIO whose both-edges bit (register 7) is 1 sets its status on a rising edge and also on a falling edge.
- R8: After reset the pin is active-low open-drain. Inactive gives pme_o=0 with pme_oe_n=1. Active gives pme_oe_n=0. In open-drain mode pme_o always equals the active level.
- R9: With config bit7 set, the pin is push-pull: pme_oe_n=0, and pme_o carries the active level (config bit0) when active and its inverse when idle.
- R10: Misc status bit3 reads the grouped signal only while config bit5 is 1, and reads 0 otherwise. Writes to bit3 have no effect.
- R11: One physical edge sets a status bit only once. Once that bit is cleared, it stays clear while the input holds its level.
- R12: If an edge and a write-one-to-clear reach the same bit in the same cycle, the bit stays set.
- R13: Ring, keyboard and mouse lines set their status on a falling edge. The fan event sets its status on a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from addr) |
| gpio_in | input | NUM_GPIO | General-purpose wake inputs (asynchronous) |
| ring_n | input | 2 | Ring-indicator lines, active low |
| kbd_data | input | 1 | Keyboard data line |
| mouse_data | input | 1 | Mouse data line |
| fan_evt | input | 1 | Fan tachometer event |
| smi_group | input | 1 | Internal grouped system-management signal (synchronous) |
| pme_o | output | 1 | Request pin data |
| pme_oe_n | output | 1 | Request pin output enable, active low |

## Verification
GPIO wake lines are driven with rising edges, falling edges and edge pairs under each invert and both-edges setting. This shows whether a given edge sets status under each sensitivity choice. Two sources are left pending and cleared one at a time, with writes of zero in between, so that the summary's dependence on every enabled bit can be seen apart from the clearing itself. An edge is made to land in the same cycle as a clear, which shows whether the new event or the clear wins. The pin is examined in all four combinations of polarity and drive mode, both idle and active.

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl #(
  parameter int NUM_GPIO = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  input  logic [NUM_GPIO-1:0] gpio_in,
  input  logic [1:0]          ring_n,
  input  logic                kbd_data,
  input  logic                mouse_data,
  input  logic                fan_evt,
  input  logic                smi_group,
  output logic                pme_o,
  output logic                pme_oe_n
);
  localparam int NG   = NUM_GPIO;
  localparam int NSRC = NG + 5;

  logic [NSRC-1:0] raw, s1, s2, prv, rise, fall;
  logic [1:0]      warm;
  logic            armed;

  assign raw = {fan_evt, mouse_data, kbd_data, ring_n, gpio_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prv <= '0; warm <= '0;
    end else begin
      s1  <= raw;
      s2  <= s1;
      prv <= s2;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end

  assign armed = (warm == 2'd3);
  assign rise  = s2 & ~prv;
  assign fall  = ~s2 & prv;

  logic          glb_en, act_hi, smi_route, push_pull;
  logic [NG-1:0] gpio_sts, gpio_en, gpio_inv, gpio_both, gpio_hit, gpio_set;
  logic [4:0]    misc_sts, misc_en_lo, misc_set;
  logic          misc_en3;
  logic [5:0]    misc_view, misc_en;

  for (genvar i = 0; i < NG; i++) begin : g_edge
    assign gpio_hit[i] = gpio_both[i] ? (rise[i] | fall[i])
                       : (gpio_inv[i] ? fall[i] : rise[i]);
  end

  assign gpio_set = gpio_hit & {NG{armed}};
  assign misc_set = {rise[NG+4], fall[NG+3], fall[NG+2], fall[NG+1], fall[NG]}
                    & {5{armed}};

  logic wr_ctl, wr_cfg, wr_gs, wr_ge, wr_ms, wr_me, wr_inv, wr_both;
  assign wr_ctl  = wr_en && addr == 3'd0;
  assign wr_cfg  = wr_en && addr == 3'd1;
  assign wr_gs   = wr_en && addr == 3'd2;
  assign wr_ge   = wr_en && addr == 3'd3;
  assign wr_ms   = wr_en && addr == 3'd4;
  assign wr_me   = wr_en && addr == 3'd5;
  assign wr_inv  = wr_en && addr == 3'd6;
  assign wr_both = wr_en && addr == 3'd7;

  logic [NG-1:0] gpio_clr;
  logic [4:0]    misc_clr;
  assign gpio_clr = wr_gs ? wdata[NG-1:0] : '0;
  assign misc_clr = wr_ms ? {wdata[5:4], wdata[2:0]} : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      glb_en <= 1'b0; act_hi <= 1'b0; smi_route <= 1'b0; push_pull <= 1'b0;
      gpio_sts <= '0; gpio_en <= '0; gpio_inv <= '0; gpio_both <= '0;
      misc_sts <= '0; misc_en_lo <= '0; misc_en3 <= 1'b0;
    end else begin
      gpio_sts <= (gpio_sts & ~gpio_clr) | gpio_set;
      misc_sts <= (misc_sts & ~misc_clr) | misc_set;
      if (wr_ctl) glb_en <= wdata[0];
      if (wr_cfg) begin
        act_hi    <= wdata[0];
        smi_route <= wdata[5];
        push_pull <= wdata[7];
      end
      if (wr_ge)   gpio_en   <= wdata[NG-1:0];
      if (wr_inv)  gpio_inv  <= wdata[NG-1:0];
      if (wr_both) gpio_both <= wdata[NG-1:0];
      if (wr_me) begin
        misc_en_lo <= {wdata[5:4], wdata[2:0]};
        misc_en3   <= wdata[3];
      end
    end

  assign misc_view = {misc_sts[4:3], smi_group & smi_route, misc_sts[2:0]};
  assign misc_en   = {misc_en_lo[4:3], misc_en3, misc_en_lo[2:0]};

  logic pending, req;
  assign pending = |(gpio_sts & gpio_en) | |(misc_view & misc_en);
  assign req     = glb_en & pending;

  assign pme_o    = push_pull ? (req ? act_hi : ~act_hi) : act_hi;
  assign pme_oe_n = push_pull ? 1'b0 : ~req;

  always_comb
    case (addr)
      3'd0:    rdata = {6'b0, pending, glb_en};
      3'd1:    rdata = {push_pull, 1'b0, smi_route, 4'b0, act_hi};
      3'd2:    rdata = 8'(gpio_sts);
      3'd3:    rdata = 8'(gpio_en);
      3'd4:    rdata = {2'b0, misc_view};
      3'd5:    rdata = {2'b0, misc_en};
      3'd6:    rdata = 8'(gpio_inv);
      default: rdata = 8'(gpio_both);
    endcase
endmodule

module wake_event_ctrl_chk #(
  parameter int NUM_GPIO = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [2:0]          addr,
  input logic [7:0]          wdata,
  input logic                glb_en,
  input logic                act_hi,
  input logic                push_pull,
  input logic                pending,
  input logic [NUM_GPIO-1:0] gpio_sts,
  input logic [NUM_GPIO-1:0] gpio_set,
  input logic                pme_o,
  input logic                pme_oe_n
);
  logic pin_active;
  assign pin_active = push_pull ? (pme_o == act_hi) : !pme_oe_n;

  // R2
  gen_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !pin_active);

  // R3
  pending_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && pending) |-> pin_active);

  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_sts[0] && !(wr_en && addr == 3'd2 && wdata[0])) |=> gpio_sts[0]);

  // R8
  od_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_pull |-> (pme_o == act_hi));

  // R9
  pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_pull |-> !pme_oe_n);

  // R12
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2 && wdata[0] && gpio_set[0]) |=> gpio_sts[0]);
endmodule

bind wake_event_ctrl wake_event_ctrl_chk #(.NUM_GPIO(NUM_GPIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .glb_en(glb_en), .act_hi(act_hi), .push_pull(push_pull), .pending(pending),
  .gpio_sts(gpio_sts), .gpio_set(gpio_set), .pme_o(pme_o), .pme_oe_n(pme_oe_n)
);

// File: tb/wake_event_ctrl_bench.sv
module wake_event_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [7:0] gpio_in = 8'd0;
  logic [1:0] ring_n = 2'b11;
  logic       kbd_data = 1'b1;
  logic       mouse_data = 1'b1;
  logic       fan_evt = 1'b0;
  logic       smi_group = 1'b0;
  logic       pme_o, pme_oe_n;
  int         total = 0;
  int         bad = 0;

  always #4 clk = ~clk;

  wake_event_ctrl #(.NUM_GPIO(8)) u_wake_event_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .gpio_in(gpio_in), .ring_n(ring_n), .kbd_data(kbd_data),
    .mouse_data(mouse_data), .fan_evt(fan_evt), .smi_group(smi_group),
    .pme_o(pme_o), .pme_oe_n(pme_oe_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic pin_chk(input string tag, input logic exp_o, input logic exp_oe_n);
    @(negedge clk);
    chk(tag, {6'b0, pme_o, pme_oe_n}, {6'b0, exp_o, exp_oe_n});
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd0, v); chk("R8 reset control", v, 8'h00);
    rd(3'd1, v); chk("R8 reset config", v, 8'h00);
    pin_chk("R8 reset pin idle", 1'b0, 1'b1);
  endtask

  task automatic t_latch_no_enable();
    logic [7:0] v;
    wr(3'd3, 8'h03);
    gpio_in[0] = 1'b1; settle();
    rd(3'd2, v); chk("R1 status with global off", v, 8'h01);
    rd(3'd0, v); chk("R1 summary with global off", v, 8'h02);
    pin_chk("R2 pin quiet with global off", 1'b0, 1'b1);
  endtask

  task automatic t_assert();
    wr(3'd0, 8'h01);
    pin_chk("R3 pin active", 1'b0, 1'b0);
    wr(3'd3, 8'h00);
    pin_chk("R3 disabled source quiet", 1'b0, 1'b1);
    wr(3'd3, 8'h03);
    pin_chk("R8 open-drain active low", 1'b0, 1'b0);
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    gpio_in[1] = 1'b1; settle();
    rd(3'd2, v); chk("R4 two pending", v, 8'h03);
    wr(3'd2, 8'h00);
    rd(3'd2, v); chk("R4 write zero keeps", v, 8'h03);
    wr(3'd2, 8'h01);
    rd(3'd2, v); chk("R4 clear one bit", v, 8'h02);
    rd(3'd0, v); chk("R5 summary still set", v, 8'h03);
    pin_chk("R5 pin still active", 1'b0, 1'b0);
    wr(3'd2, 8'h02);
    rd(3'd0, v); chk("R5 summary cleared", v, 8'h01);
    pin_chk("R5 pin released", 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    rd(3'd2, v); chk("R11 single set per edge", v, 8'h00);
  endtask

  task automatic t_gpio_polarity();
    logic [7:0] v;
    gpio_in[0] = 1'b0; settle();
    rd(3'd2, v); chk("R6 falling ignored non-inverted", v, 8'h00);
    gpio_in[3] = 1'b1; settle();
    rd(3'd2, v); chk("R6 rising sets non-inverted", v, 8'h08);
    wr(3'd2, 8'h08);
    wr(3'd6, 8'h04);
    gpio_in[2] = 1'b1; settle();
    rd(3'd2, v); chk("R6 rising ignored inverted", v, 8'h00);
    gpio_in[2] = 1'b0; settle();
    rd(3'd2, v); chk("R6 falling sets inverted", v, 8'h04);
    wr(3'd2, 8'h04);
  endtask

  task automatic t_both_edges();
    logic [7:0] v;
    wr(3'd7, 8'h10);
    gpio_in[4] = 1'b1; settle();
    rd(3'd2, v); chk("R7 rising in both mode", v, 8'h10);
    wr(3'd2, 8'h10);
    gpio_in[4] = 1'b0; settle();
    rd(3'd2, v); chk("R7 falling in both mode", v, 8'h10);
    wr(3'd2, 8'h10);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    wr(3'd7, 8'h20);
    gpio_in[5] = 1'b1; settle();
    @(negedge clk); gpio_in[5] = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 3'd2; wdata = 8'h20;
    @(negedge clk); wr_en = 1'b0;
    settle();
    rd(3'd2, v); chk("R12 edge beats clear", v, 8'h20);
    wr(3'd2, 8'h20);
    rd(3'd2, v); chk("R4 plain clear", v, 8'h00);
  endtask

  task automatic t_misc();
    logic [7:0] v;
    ring_n[0] = 1'b0; kbd_data = 1'b0; mouse_data = 1'b0; fan_evt = 1'b1; settle();
    rd(3'd4, v); chk("R13 misc sources", v, 8'h35);
    ring_n[0] = 1'b1; kbd_data = 1'b1; mouse_data = 1'b1; fan_evt = 1'b0; settle();
    rd(3'd4, v); chk("R13 opposite edges ignored", v, 8'h35);
    wr(3'd4, 8'h3f);
    ring_n[1] = 1'b0; settle();
    rd(3'd4, v); chk("R13 ring1 falling", v, 8'h02);
    wr(3'd4, 8'h02);
  endtask

  task automatic t_smi();
    logic [7:0] v;
    smi_group = 1'b1; settle();
    rd(3'd4, v); chk("R10 mirror gated off", v, 8'h00);
    wr(3'd1, 8'h20);
    rd(3'd4, v); chk("R10 mirror routed", v, 8'h08);
    wr(3'd4, 8'h08);
    rd(3'd4, v); chk("R10 write to mirror ignored", v, 8'h08);
    smi_group = 1'b0;
    rd(3'd4, v); chk("R10 mirror follows", v, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_modes();
    wr(3'd1, 8'h80);
    pin_chk("R9 push-pull low idle", 1'b1, 1'b0);
    gpio_in[0] = 1'b1; settle();
    pin_chk("R9 push-pull low active", 1'b0, 1'b0);
    wr(3'd1, 8'h81);
    pin_chk("R9 push-pull high active", 1'b1, 1'b0);
    wr(3'd1, 8'h01);
    pin_chk("R8 open-drain high active", 1'b1, 1'b0);
    wr(3'd2, 8'h01);
    pin_chk("R8 open-drain high idle", 1'b1, 1'b1);
    wr(3'd1, 8'h81);
    pin_chk("R9 push-pull high idle", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_latch_no_enable();
    t_assert();
    t_w1c();
    t_gpio_polarity();
    t_both_edges();
    t_collide();
    t_misc();
    t_smi();
    t_modes();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule